// File: doc/BRIEF.md
# Peripheral Interrupt Flag Controller

This block holds the pending-event flags and the per-source enable mask for a peripheral with several interrupt sources, such as a finished result, a threshold crossing, a lost sample and a completed clock-domain handoff. The peripheral core presents one condition pulse per source. Each pulse latches a sticky flag. A source raises its request when its flag is set and its enable bit is set.

Software reaches the block over a small register port with a write strobe, an address, write data and combinational read data. Enables change only through two addresses: one where written ones enable, and one where written ones disable. Flags are cleared by writing ones to the flag address. A write therefore never needs a read-modify-write cycle. The block drives one request line per source and one common line that is the OR of all of them. A handler that uses the common line reads the flag address to learn which source fired.

The register port has no back-pressure. A write is accepted in the cycle its strobe is high, and read data follows the address in the same cycle. This keeps the port plain and avoids any handshake.

Top module: `irq_flag_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, all flags and all enables clear. After reset, every request output is low.
- R2: A high bit on `cond_i` at a clock edge sets that source's flag. The flag stays set after the pulse ends.
- R3: A write to address 1 (enable-set) turns on the enable of each source whose write-data bit is 1. Bits written as 0 leave their enables unchanged.
- R4: A write to address 2 (enable-clear) turns off the enable of each source whose write-data bit is 1. Bits written as 0 leave their enables unchanged.
- R5: `irq_src_o[i]` is high exactly when flag i and enable i are both set.
- R6: A request stays high until its flag is cleared, its enable is removed, or reset occurs.
- R7: A write to address 0 (flags) clears each flag whose write-data bit is 1. Bits written as 0 have no effect.
- R8: If a condition pulse and a flag-clear write hit the same bit at the same clock edge, the flag ends up set.
- R9: `irq_any_o` is the OR of all per-source requests.
- R10: Read data shows the flags at address 0 and the enable mask at address 1 and at address 2. It is all zero at address 3. Bit i always belongs to source i.
- R11: A flag sets even while its enable is off. Its request appears as soon as the enable is turned on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_i | input | N_SRC | Per-source condition pulses from the peripheral core |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address (0 flags, 1 enable-set, 2 enable-clear) |
| bus_wdata_i | input | N_SRC | Register write data, one bit per source |
| bus_rdata_o | output | N_SRC | Register read data for the current address |
| irq_src_o | output | N_SRC | Per-source request lines |
| irq_any_o | output | 1 | Common request line |

## Verification
The bench sends condition pulses to separate and to overlapping sources while their enables are off. This shows that flag latching does not depend on the enable mask. It then writes to the enable and flag addresses with some data bits at zero and some at one, which shows that zero bits leave state alone and one bits act only on their own source. A clear write that lands in the same cycle as a fresh pulse on one of the cleared bits separates a design where the set wins from one where the clear wins. A reset taken while every flag and enable is active shows that all stored state is cleared.

// File: rtl/irqf_pkg.sv
package irqf_pkg;

  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_FLAG  = 2'd0,
    REG_ENSET = 2'd1,
    REG_ENCLR = 2'd2,
    REG_VOID  = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/irqf_decode.sv
module irqf_decode
  import irqf_pkg::*;
#(
  parameter int N_SRC = 4
) (
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_SRC-1:0]  flags_i,
  input  logic [N_SRC-1:0]  enables_i,
  output logic              flag_clr_stb_o,
  output logic              en_set_stb_o,
  output logic              en_clr_stb_o,
  output logic [N_SRC-1:0]  rdata_o
);

  reg_sel_e sel;

  always_comb begin
    sel            = reg_sel_e'(addr_i);
    flag_clr_stb_o = wr_i && (sel == REG_FLAG);
    en_set_stb_o   = wr_i && (sel == REG_ENSET);
    en_clr_stb_o   = wr_i && (sel == REG_ENCLR);
  end

  always_comb begin
    unique case (sel)
      REG_FLAG:  rdata_o = flags_i;
      REG_ENSET: rdata_o = enables_i;
      REG_ENCLR: rdata_o = enables_i;
      default:   rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/irqf_flag_bank.sv
module irqf_flag_bank #(
  parameter int N_SRC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] cond_i,
  input  logic             clr_stb_i,
  input  logic [N_SRC-1:0] clr_mask_i,
  output logic [N_SRC-1:0] flags_o
);

  for (genvar i = 0; i < N_SRC; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) begin
        flags_o[i] <= 1'b0;
      end else if (cond_i[i]) begin
        flags_o[i] <= 1'b1;
      end else if (clr_stb_i && clr_mask_i[i]) begin
        flags_o[i] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/irqf_enable_bank.sv
module irqf_enable_bank #(
  parameter int N_SRC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_stb_i,
  input  logic             clr_stb_i,
  input  logic [N_SRC-1:0] mask_i,
  output logic [N_SRC-1:0] enables_o
);

  for (genvar i = 0; i < N_SRC; i++) begin : g_en
    always_ff @(posedge clk) begin
      if (rst) begin
        enables_o[i] <= 1'b0;
      end else if (set_stb_i && mask_i[i]) begin
        enables_o[i] <= 1'b1;
      end else if (clr_stb_i && mask_i[i]) begin
        enables_o[i] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irqf_pkg::*;
#(
  parameter int N_SRC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  cond_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [N_SRC-1:0]  bus_wdata_i,
  output logic [N_SRC-1:0]  bus_rdata_o,
  output logic [N_SRC-1:0]  irq_src_o,
  output logic              irq_any_o
);

  logic [N_SRC-1:0] flags;
  logic [N_SRC-1:0] enables;
  logic             flag_clr_stb;
  logic             en_set_stb;
  logic             en_clr_stb;

  irqf_decode #(.N_SRC(N_SRC)) u_decode (
    .wr_i           (bus_wr_i),
    .addr_i         (bus_addr_i),
    .flags_i        (flags),
    .enables_i      (enables),
    .flag_clr_stb_o (flag_clr_stb),
    .en_set_stb_o   (en_set_stb),
    .en_clr_stb_o   (en_clr_stb),
    .rdata_o        (bus_rdata_o)
  );

  irqf_flag_bank #(.N_SRC(N_SRC)) u_flags (
    .clk        (clk),
    .rst        (rst),
    .cond_i     (cond_i),
    .clr_stb_i  (flag_clr_stb),
    .clr_mask_i (bus_wdata_i),
    .flags_o    (flags)
  );

  irqf_enable_bank #(.N_SRC(N_SRC)) u_enables (
    .clk       (clk),
    .rst       (rst),
    .set_stb_i (en_set_stb),
    .clr_stb_i (en_clr_stb),
    .mask_i    (bus_wdata_i),
    .enables_o (enables)
  );

  for (genvar i = 0; i < N_SRC; i++) begin : g_req
    assign irq_src_o[i] = flags[i] & enables[i];
  end

  assign irq_any_o = |irq_src_o;

endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk
  import irqf_pkg::*;
#(
  parameter int N_SRC = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [N_SRC-1:0]  cond_i,
  input logic              bus_wr_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [N_SRC-1:0]  bus_wdata_i,
  input logic [N_SRC-1:0]  bus_rdata_o,
  input logic [N_SRC-1:0]  flags,
  input logic [N_SRC-1:0]  enables
);

  // R2
  flag_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (cond_i != '0) |=> ((flags & $past(cond_i)) == $past(cond_i)));

  // R3
  en_set_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_i && bus_addr_i == REG_ENSET) |=>
      (enables == ($past(enables) | $past(bus_wdata_i))));

  // R4
  en_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_i && bus_addr_i == REG_ENCLR) |=>
      (enables == ($past(enables) & ~$past(bus_wdata_i))));

  // R7
  flag_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_i && bus_addr_i == REG_FLAG) |=>
      ((flags & $past(flags) & ~$past(bus_wdata_i)) == ($past(flags) & ~$past(bus_wdata_i))));

  // R10
  rd_en_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_addr_i == REG_ENSET || bus_addr_i == REG_ENCLR) |-> (bus_rdata_o == enables));

endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk #(.N_SRC(N_SRC)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cond_i      (cond_i),
  .bus_wr_i    (bus_wr_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .flags       (flags),
  .enables     (enables)
);

// File: tb/irq_flag_ctrl_tb_top.sv
module irq_flag_ctrl_tb_top;

  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] cond;
  logic         wr;
  logic [1:0]   addr;
  logic [N-1:0] wdata;
  logic [N-1:0] rdata;
  logic [N-1:0] irq;
  logic         any;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  irq_flag_ctrl #(.N_SRC(N)) dut_i (
    .clk         (clk),
    .rst         (rst),
    .cond_i      (cond),
    .bus_wr_i    (wr),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_src_o   (irq),
    .irq_any_o   (any)
  );

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [N-1:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [N-1:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic pulse(input logic [N-1:0] c);
    @(negedge clk);
    cond = c;
    @(negedge clk);
    cond = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    logic [N-1:0] v;
    do_reset();
    bus_read(2'd0, v); check("R1 flags after reset", v, '0);
    bus_read(2'd1, v); check("R1 enables after reset", v, '0);
    check("R1 requests after reset", irq, '0);
  endtask

  task automatic t_latch_disabled();
    logic [N-1:0] v;
    pulse(4'b0101);
    @(negedge clk);
    bus_read(2'd0, v); check("R2 flags held after pulse", v, 4'b0101);
    check("R11 no request while disabled", irq, '0);
  endtask

  task automatic t_enable_set();
    logic [N-1:0] v;
    bus_write(2'd1, 4'b0001);
    bus_read(2'd1, v); check("R10 enable via set address", v, 4'b0001);
    bus_read(2'd2, v); check("R10 enable via clear address", v, 4'b0001);
    check("R11 R5 request on enable", irq, 4'b0001);
    check("R9 common line", {3'b0, any}, 4'b0001);
    bus_write(2'd1, 4'b0000);
    bus_read(2'd1, v); check("R3 zero bits keep enables", v, 4'b0001);
    bus_write(2'd1, 4'b0100);
    bus_read(2'd1, v); check("R3 second set accumulates", v, 4'b0101);
    check("R5 two requests", irq, 4'b0101);
  endtask

  task automatic t_enable_clear();
    logic [N-1:0] v;
    bus_write(2'd2, 4'b0001);
    bus_read(2'd2, v); check("R4 clear one enable", v, 4'b0100);
    check("R6 request drops with enable", irq, 4'b0100);
    bus_read(2'd0, v); check("R6 flag kept when disabled", v, 4'b0101);
    bus_write(2'd2, 4'b0000);
    bus_read(2'd1, v); check("R4 zero bits keep enables", v, 4'b0100);
  endtask

  task automatic t_flag_clear();
    logic [N-1:0] v;
    bus_write(2'd0, 4'b0000);
    bus_read(2'd0, v); check("R7 zero write keeps flags", v, 4'b0101);
    check("R6 request held", irq, 4'b0100);
    bus_write(2'd0, 4'b0100);
    bus_read(2'd0, v); check("R7 one clears flag", v, 4'b0001);
    check("R6 request drops with flag", irq, 4'b0000);
    check("R9 common line low", {3'b0, any}, 4'b0000);
  endtask

  task automatic t_collide();
    logic [N-1:0] v;
    @(negedge clk);
    cond = 4'b0010; wr = 1'b1; addr = 2'd0; wdata = 4'b0011;
    @(negedge clk);
    cond = '0; wr = 1'b0; wdata = '0;
    bus_read(2'd0, v); check("R8 set wins over clear", v, 4'b0010);
  endtask

  task automatic t_unused_addr();
    logic [N-1:0] v;
    bus_read(2'd3, v); check("R10 unused address reads zero", v, '0);
  endtask

  task automatic t_multi();
    bus_write(2'd1, 4'b1111);
    pulse(4'b1000);
    check("R9 R2 single high source", {3'b0, any}, 4'b0001);
    check("R5 pattern", irq, 4'b1010);
  endtask

  task automatic t_reset_busy();
    logic [N-1:0] v;
    pulse(4'b1111);
    check("R5 all requests", irq, 4'b1111);
    do_reset();
    bus_read(2'd0, v); check("R1 flags cleared mid-run", v, '0);
    bus_read(2'd2, v); check("R1 enables cleared mid-run", v, '0);
    check("R1 requests cleared mid-run", irq, '0);
  endtask

  initial begin
    rst = 1'b1; cond = '0; wr = 1'b0; addr = '0; wdata = '0;
    t_reset();
    t_latch_disabled();
    t_enable_set();
    t_enable_clear();
    t_flag_clear();
    t_collide();
    t_unused_addr();
    t_multi();
    t_reset_busy();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #50000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule